// File: doc/BRIEF.md
# Correlation Detector Write Pulse Sequencer

This block sits in a memory controller in front of an array of resistive memory devices, and the array does the correlation detection itself. Every time step, the block receives one event vector with a single bit per input stream. It counts the set bits to get the step's momentum. It multiplies that count by a programmable fixed-point scale to get a programming-current code. It then issues a SET write, one command at a time, to every device that belongs to a stream whose bit is set. All writes in a step use the same code. A step whose code falls below a floor issues no writes at all. A code above a ceiling is clamped to the ceiling.

The block has two more jobs. A RESET pass programs every device with a fixed high-current RESET, and it starts a new detection window. A read sweep reads every device in address order and hands the 8-bit results back in that same order. Each stream owns several neighbouring devices. The device index becomes a word-line and bit-line address. The analog array is replaced by a command port with a valid/ready handshake and a response port.

Top module: `corr_write_seq`

## Requirements
- R1: The current code of a step is floor(scale × M / 65536), where M is the number of set bits in the vector and scale has 16 fractional bits. A code above CEIL (800, which is 80 µA in 0.1 µA units) is sent as CEIL.
- R2: A step whose unclamped code is below FLOOR (250, which is 25 µA) is accepted but issues no command, and busy stays low.
- R3: A non-skipped step issues one SET command (cmd_op = 0) for each device of each set stream and none for other devices. Commands go in ascending device order, and each carries the step's code.
- R4: Device d = s × DEV_PER + k belongs to stream s. Its address is word line d / BL_N and bit line d mod BL_N.
- R5: A RESET pass issues cmd_op = 1 with code 4400 (440 µA) to every device in ascending order.
- R6: A read sweep issues cmd_op = 2 with code 0 for each device in ascending order. It issues no next read until the response to the previous read has arrived. Each response appears on res_valid/res_data together with that device's address.
- R7: While cmd_valid is high and cmd_ready is low, cmd_op, the address and cmd_cur stay unchanged.
- R8: From the cycle after a non-skipped step is accepted until its last write is taken, busy is high and step_ready is low. When both requests and a step arrive together, RESET wins over the sweep, and the sweep wins over the step.
- R9: After reset, busy and cmd_valid are low and step_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scale | input | SCALE_W | Code units per count, 16 fractional bits |
| step_valid | input | 1 | Event vector offered |
| step_bits | input | N_STREAM | One event bit per stream |
| step_ready | output | 1 | Vector taken this cycle if valid |
| reset_req | input | 1 | Start a RESET pass (sampled when idle) |
| sweep_req | input | 1 | Start a read sweep (sampled when idle) |
| busy | output | 1 | A step, pass or sweep is in progress |
| cmd_valid | output | 1 | Array command offered |
| cmd_ready | input | 1 | Array takes the command |
| cmd_op | output | 2 | 0 SET, 1 RESET, 2 READ |
| cmd_wl | output | log2(WL_N) | Word-line address |
| cmd_bl | output | log2(BL_N) | Bit-line address |
| cmd_cur | output | CODE_W | Current code in 0.1 µA units |
| rsp_valid | input | 1 | Read result from array |
| rsp_data | input | RD_W | Read result value |
| res_valid | output | 1 | Read result forwarded |
| res_data | output | RD_W | Forwarded read value |
| res_wl | output | log2(WL_N) | Word line of the result |
| res_bl | output | log2(BL_N) | Bit line of the result |

## Verification
The momentum and the current code are combinational, and the code is latched on the edge that accepts the step. The first command can appear from the next cycle on, and busy rises one cycle after acceptance. The bench therefore samples busy at the first falling edge after the accepting edge. It records every command at the falling edge before the edge that hands it over, and compares the whole recorded list only after busy has fallen. A read result is forwarded in the same cycle the array answers. For each read handshake, the bench checks that all earlier results have already been seen.

// File: rtl/corr_seq_pkg.sv
package corr_seq_pkg;
   typedef enum logic [1:0] {
      OP_SET   = 2'd0,
      OP_RESET = 2'd1,
      OP_READ  = 2'd2
   } cmd_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_SET,
      S_RST,
      S_RDC,
      S_RDW
   } seq_state_e;
endpackage

// File: rtl/corr_momentum.sv
module corr_momentum #(
   parameter int N_STREAM = 8,
   parameter int CNT_W    = $clog2(N_STREAM + 1)
) (
   input  logic [N_STREAM-1:0] bits,
   output logic [CNT_W-1:0]    count
);
   always_comb begin
      count = '0;
      for (int i = 0; i < N_STREAM; i++)
         count = count + CNT_W'(bits[i]);
   end
endmodule

// File: rtl/corr_current.sv
module corr_current #(
   parameter int CNT_W   = 4,
   parameter int SCALE_W = 24,
   parameter int FRAC_W  = 16,
   parameter int CODE_W  = 13,
   parameter int FLOOR   = 250,
   parameter int CEIL    = 800
) (
   input  logic [CNT_W-1:0]   count,
   input  logic [SCALE_W-1:0] scale,
   output logic [CODE_W-1:0]  code,
   output logic               skip
);
   localparam int PROD_W = SCALE_W + CNT_W;
   localparam int RAW_W  = PROD_W - FRAC_W;

   if (FRAC_W >= SCALE_W) begin : g_bad_frac
      $error("scale needs integer bits");
   end
   if (CEIL >= (1 << CODE_W)) begin : g_bad_ceil
      $error("ceiling does not fit the code width");
   end

   logic [PROD_W-1:0] prod;
   logic [RAW_W-1:0]  raw;

   always_comb begin
      prod = PROD_W'(scale) * PROD_W'(count);
      raw  = RAW_W'(prod >> FRAC_W);
      skip = raw < RAW_W'(FLOOR);
      code = (raw > RAW_W'(CEIL)) ? CODE_W'(CEIL) : CODE_W'(raw);
   end
endmodule

// File: rtl/corr_addr.sv
module corr_addr #(
   parameter int NDEV = 32,
   parameter int WL_N = 512,
   parameter int BL_N = 2048,
   parameter int DEV_W = $clog2(NDEV),
   parameter int WL_W = $clog2(WL_N),
   parameter int BL_W = $clog2(BL_N)
) (
   input  logic [DEV_W-1:0] dev,
   output logic [WL_W-1:0]  wl,
   output logic [BL_W-1:0]  bl
);
   if ((1 << BL_W) == BL_N) begin : g_pow2
      assign bl = BL_W'(dev);
      assign wl = WL_W'(dev >> BL_W);
   end else begin : g_div
      assign bl = BL_W'(32'(dev) % BL_N);
      assign wl = WL_W'(32'(dev) / BL_N);
   end
endmodule

// File: rtl/corr_write_seq.sv
module corr_write_seq
   import corr_seq_pkg::*;
#(
   parameter int N_STREAM   = 8,
   parameter int DEV_PER    = 4,
   parameter int WL_N       = 512,
   parameter int BL_N       = 2048,
   parameter int SCALE_W    = 24,
   parameter int FRAC_W     = 16,
   parameter int CODE_W     = 13,
   parameter int FLOOR      = 250,
   parameter int CEIL       = 800,
   parameter int RESET_CODE = 4400,
   parameter int RD_W       = 8,
   localparam int WL_W      = $clog2(WL_N),
   localparam int BL_W      = $clog2(BL_N)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SCALE_W-1:0]  scale,
   input  logic                step_valid,
   input  logic [N_STREAM-1:0] step_bits,
   output logic                step_ready,
   input  logic                reset_req,
   input  logic                sweep_req,
   output logic                busy,
   output logic                cmd_valid,
   input  logic                cmd_ready,
   output logic [1:0]          cmd_op,
   output logic [WL_W-1:0]     cmd_wl,
   output logic [BL_W-1:0]     cmd_bl,
   output logic [CODE_W-1:0]   cmd_cur,
   input  logic                rsp_valid,
   input  logic [RD_W-1:0]     rsp_data,
   output logic                res_valid,
   output logic [RD_W-1:0]     res_data,
   output logic [WL_W-1:0]     res_wl,
   output logic [BL_W-1:0]     res_bl
);
   localparam int NDEV  = N_STREAM * DEV_PER;
   localparam int DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1;
   localparam int CNT_W = $clog2(N_STREAM + 1);

   if (NDEV > WL_N * BL_N) begin : g_bad_size
      $error("more devices than array cells");
   end
   if (RESET_CODE >= (1 << CODE_W)) begin : g_bad_rst
      $error("reset code does not fit");
   end
   if (FLOOR > CEIL) begin : g_bad_win
      $error("floor above ceiling");
   end

   seq_state_e          state;
   logic [DEV_W-1:0]    dev;
   logic [N_STREAM-1:0] bits_q;
   logic [CODE_W-1:0]   cur_q;
   logic [NDEV-1:0]     dev_mask;
   logic [CNT_W-1:0]    mom;
   logic [CODE_W-1:0]   code;
   logic                skip;
   logic                active;
   logic                last;

   corr_momentum #(.N_STREAM(N_STREAM), .CNT_W(CNT_W)) u_mom (
      .bits(step_bits), .count(mom)
   );

   corr_current #(
      .CNT_W(CNT_W), .SCALE_W(SCALE_W), .FRAC_W(FRAC_W),
      .CODE_W(CODE_W), .FLOOR(FLOOR), .CEIL(CEIL)
   ) u_cur (
      .count(mom), .scale(scale), .code(code), .skip(skip)
   );

   corr_addr #(.NDEV(NDEV), .WL_N(WL_N), .BL_N(BL_N), .DEV_W(DEV_W)) u_addr (
      .dev(dev), .wl(cmd_wl), .bl(cmd_bl)
   );

   for (genvar s = 0; s < N_STREAM; s++) begin : g_strm
      for (genvar k = 0; k < DEV_PER; k++) begin : g_dev
         assign dev_mask[s*DEV_PER+k] = bits_q[s];
      end
   end

   assign active     = dev_mask[dev];
   assign last       = dev == DEV_W'(NDEV - 1);
   assign busy       = state != S_IDLE;
   assign step_ready = (state == S_IDLE) && !reset_req && !sweep_req;
   assign res_valid  = (state == S_RDW) && rsp_valid;
   assign res_data   = rsp_data;
   assign res_wl     = cmd_wl;
   assign res_bl     = cmd_bl;

   always_comb begin
      cmd_valid = 1'b0;
      cmd_op    = OP_SET;
      cmd_cur   = '0;
      case (state)
         S_SET: begin cmd_valid = active; cmd_cur = cur_q; end
         S_RST: begin cmd_valid = 1'b1; cmd_op = OP_RESET; cmd_cur = CODE_W'(RESET_CODE); end
         S_RDC: begin cmd_valid = 1'b1; cmd_op = OP_READ; end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         dev    <= '0;
         bits_q <= '0;
         cur_q  <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               dev <= '0;
               if (reset_req)
                  state <= S_RST;
               else if (sweep_req)
                  state <= S_RDC;
               else if (step_valid && !skip) begin
                  bits_q <= step_bits;
                  cur_q  <= code;
                  state  <= S_SET;
               end
            end
            S_SET: if (!active || cmd_ready) begin
               if (last) state <= S_IDLE;
               else      dev <= dev + 1'b1;
            end
            S_RST: if (cmd_ready) begin
               if (last) state <= S_IDLE;
               else      dev <= dev + 1'b1;
            end
            S_RDC: if (cmd_ready) state <= S_RDW;
            S_RDW: if (rsp_valid) begin
               if (last) state <= S_IDLE;
               else begin
                  dev   <= dev + 1'b1;
                  state <= S_RDC;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R7
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_wl)
                                  && $stable(cmd_bl) && $stable(cmd_cur));
   // R1
   set_cur_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == OP_SET |-> cmd_cur >= CODE_W'(FLOOR) && cmd_cur <= CODE_W'(CEIL));
   // R5
   reset_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == OP_RESET |-> cmd_cur == CODE_W'(RESET_CODE));
   // R8
   step_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid && step_ready && !skip |=> busy && !step_ready);
   // R6
   read_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !cmd_valid);
   // R3
   op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_op != 2'd3);
endmodule

// File: tb/sim_corr_write_seq.sv
module sim_corr_write_seq;
   localparam int NS = 8, DP = 2, WLN = 8, BLN = 4, ND = NS * DP;

   logic clk = 0, rst_n = 0;
   logic [23:0] scale = '0;
   logic step_valid = 0, reset_req = 0, sweep_req = 0;
   logic [NS-1:0] step_bits = '0;
   logic step_ready, busy, cmd_valid, res_valid;
   logic cmd_ready = 0, rsp_valid = 0;
   logic [1:0] cmd_op;
   logic [2:0] cmd_wl, res_wl;
   logic [1:0] cmd_bl, res_bl;
   logic [12:0] cmd_cur;
   logic [7:0] rsp_data = '0, res_data;

   int total = 0, fails = 0, cycles = 0;
   int log_n = 0, res_n = 0, bad_rdy = 0, rd_hs_cnt = 0, rd_hs_dev = 0;
   int log_op[0:63], log_wl[0:63], log_bl[0:63], log_cur[0:63], log_resat[0:63];
   int rs_data[0:63], rs_wl[0:63], rs_bl[0:63];
   int rd_done = 0, rd_wait = 0, rd_dev = 0, rdy_cnt = 0;

   corr_write_seq #(.N_STREAM(NS), .DEV_PER(DP), .WL_N(WLN), .BL_N(BLN)) u0 (
      .clk, .rst_n, .scale, .step_valid, .step_bits, .step_ready, .reset_req,
      .sweep_req, .busy, .cmd_valid, .cmd_ready, .cmd_op, .cmd_wl, .cmd_bl,
      .cmd_cur, .rsp_valid, .rsp_data, .res_valid, .res_data, .res_wl, .res_bl);

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         total++; fails++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   // array model: ready pattern and read responses two cycles after a read
   always @(posedge clk) begin
      #1;
      if (rd_hs_cnt != rd_done) begin rd_done = rd_hs_cnt; rd_wait = 2; rd_dev = rd_hs_dev; end
      rsp_valid = (rd_wait == 1);
      rsp_data  = 8'(rd_dev * 37 + 5);
      if (rd_wait > 0) rd_wait--;
      cmd_ready = (rdy_cnt % 3) != 0;
      rdy_cnt++;
   end

   always @(negedge clk) if (rst_n) begin
      if (cmd_valid && cmd_ready && log_n < 64) begin
         log_op[log_n] = int'(cmd_op); log_wl[log_n] = int'(cmd_wl);
         log_bl[log_n] = int'(cmd_bl); log_cur[log_n] = int'(cmd_cur);
         log_resat[log_n] = res_n; log_n++;
         if (cmd_op == 2'd2) begin rd_hs_dev = int'(cmd_wl) * BLN + int'(cmd_bl); rd_hs_cnt++; end
      end
      if (res_valid && res_n < 64) begin
         rs_data[res_n] = int'(res_data); rs_wl[res_n] = int'(res_wl);
         rs_bl[res_n] = int'(res_bl); res_n++;
      end
      if (busy && step_ready) bad_rdy++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_code(input longint sc, input int m);
      longint raw = (sc * m) >>> 16;
      return (raw > 800) ? 800 : int'(raw);
   endfunction

   function automatic int pack(input int op, input int wl, input int bl, input int cur);
      return (op << 24) | (wl << 20) | (bl << 16) | cur;
   endfunction

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic run_step(input logic [NS-1:0] b);
      int m = $countones(b);
      longint raw = (longint'(scale) * m) >>> 16;
      bit sk = raw < 250;
      int cd = exp_code(longint'(scale), m);
      int idx = 0;
      @(negedge clk);
      while (!step_ready) @(negedge clk);
      log_n = 0; bad_rdy = 0;
      step_bits = b; step_valid = 1;
      @(posedge clk); #1 step_valid = 0;
      @(negedge clk);
      // R2 R8: busy one cycle after acceptance only for non-skipped steps
      chk(busy == !sk, sk ? "R2" : "R8", "busy after accept", busy, !sk);
      wait_idle();
      for (int d = 0; d < ND; d++) if (b[d / DP]) begin
         // R1 R3 R4: op SET, address d/BLN, d%BLN, step code
         if (!sk && idx < log_n)
            chk(pack(log_op[idx], log_wl[idx], log_bl[idx], log_cur[idx]) ==
                pack(0, d / BLN, d % BLN, cd), "R3", "set cmd",
                pack(log_op[idx], log_wl[idx], log_bl[idx], log_cur[idx]),
                pack(0, d / BLN, d % BLN, cd));
         idx++;
      end
      chk(log_n == (sk ? 0 : idx), sk ? "R2" : "R3", "write count", log_n, sk ? 0 : idx);
      chk(bad_rdy == 0, "R8", "ready while busy", bad_rdy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9
      chk(!busy && !cmd_valid, "R9", "idle in reset", {busy, cmd_valid}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && !cmd_valid && step_ready, "R9", "after reset",
          {busy, cmd_valid, step_ready}, 3'b001);

      // R5 and R8 priority: all three requests together, RESET wins
      reset_req = 1; sweep_req = 1; step_valid = 1; step_bits = '1; scale = 24'h3C0000;
      log_n = 0; res_n = 0;
      #1 chk(!step_ready, "R8", "ready with requests", step_ready, 0);
      @(posedge clk); #1 reset_req = 0; sweep_req = 0; step_valid = 0;
      wait_idle();
      chk(log_n == ND, "R5", "reset count", log_n, ND);
      for (int d = 0; d < ND && d < log_n; d++)
         chk(pack(log_op[d], log_wl[d], log_bl[d], log_cur[d]) ==
             pack(1, d / BLN, d % BLN, 4400), "R5", "reset cmd",
             pack(log_op[d], log_wl[d], log_bl[d], log_cur[d]),
             pack(1, d / BLN, d % BLN, 4400));

      // R1 R2 R3 R4: exhaustive vectors under several scales
      for (int s = 0; s < 4; s++) begin
         case (s)
            0: scale = 24'h3C0000;   // 60 per count
            1: scale = 24'h968000;   // 150.5 per count, clamps
            2: scale = 24'h215555;   // 33.33 per count, truncation
            default: scale = 24'h008000; // 0.5, always skipped
         endcase
         for (int v = 0; v < 256; v++) run_step(NS'(v));
      end

      // R6: read sweep
      log_n = 0; res_n = 0;
      @(negedge clk); sweep_req = 1;
      @(posedge clk); #1 sweep_req = 0;
      wait_idle();
      chk(log_n == ND && res_n == ND, "R6", "read counts", {log_n, res_n}, {ND, ND});
      for (int d = 0; d < ND && d < log_n && d < res_n; d++) begin
         chk(pack(log_op[d], log_wl[d], log_bl[d], log_cur[d]) ==
             pack(2, d / BLN, d % BLN, 0), "R6", "read cmd",
             pack(log_op[d], log_wl[d], log_bl[d], log_cur[d]), pack(2, d / BLN, d % BLN, 0));
         chk(log_resat[d] == d, "R6", "read before response", log_resat[d], d);
         chk(pack(0, rs_wl[d], rs_bl[d], rs_data[d]) ==
             pack(0, d / BLN, d % BLN, (d * 37 + 5) & 255), "R6", "result",
             pack(0, rs_wl[d], rs_bl[d], rs_data[d]), pack(0, d / BLN, d % BLN, (d * 37 + 5) & 255));
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule